// File: doc/BRIEF.md
# Per-Channel Loopback and Signalling Control

This block keeps one 8-bit control word for every channel of a framed 8-bit-per-channel stream. The stream has 24 channels in T1 mode and 32 in E1 mode. When each channel begins, the block looks up that channel's word and applies it to two parallel byte paths. The first path carries transmit-side backplane data out to the line. The second carries received line data to the receive-side backplane output. Each word can loop either path, or both, independently. Word index n always governs channel n in both directions.

The same word also selects where the transmit signalling bit for the channel comes from. It comes either from a per-channel signalling register that is written over the register port, or from the signalling input stream, which is sampled at the start of the channel. In T1 mode the word can also stop robbed-bit signalling for the channel. Otherwise the signalling bit replaces the LSB of the outgoing byte while the frame marker input says this is a signalling frame.

Register writes go into storage at once. The data path only sees a new word at the next channel boundary, so no channel changes behaviour partway through a byte.

Top module: `ts_ctrl`

## Requirements
- R1: Writing a word to control address n (reg_addr[5]=0, reg_addr[4:0]=n) makes reg_rdata return that word from the next cycle. All 8 bits are stored. Bits 7, 6, 3 and 2 have no effect on either data output.
- R2: In T1 mode (mode_e1=0), writes to channel numbers 24..31 in either bank are ignored and read back as 0. Channels 24..31 pass data through unchanged: line_tx_out=bp_tx_in and bp_rx_out=line_rx_in.
- R3: Control bit 4 set for a channel makes bp_rx_out equal bp_tx_in during that channel.
- R4: Control bit 5 set for a channel makes line_tx_out equal line_rx_in during that channel.
- R5: Bits 4 and 5 act independently. Both may be set at once, and then each output takes the other direction's input.
- R6: The data path uses the word that was stored when the channel's ts_start edge occurred. A write during the channel does not change the outputs until the next boundary of that channel.
- R7: Signalling bank address n (reg_addr[5]=1) reads the channel's signalling bit on reg_rdata[0]. With control bit 1 clear, each boundary of channel n reloads that bit from sig_in. With bit 1 set, the bit keeps the value written over the register port.
- R8: In T1 mode, when rob_frame is high at the boundary and bits 0 and 5 are clear, line_tx_out[0] carries the channel's signalling bit and bits 7..1 carry bp_tx_in. The signalling bit is the register value if bit 1 is set, otherwise sig_in at the boundary. When rob_frame is low, the byte passes unchanged.
- R9: In T1 mode, control bit 0 set stops robbing for the channel. In E1 mode, no robbing occurs and bit 0 has no effect.
- R10: After reset all words and signalling bits are 0 and both outputs pass their inputs through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_e1 | input | 1 | 1 = 32-channel mode, 0 = 24-channel mode with robbing |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Bit 5 selects the bank (0 control, 1 signalling); bits 4:0 give the channel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ts_start | input | 1 | One-cycle pulse at each channel boundary |
| ts_num | input | 5 | Number of the channel starting at ts_start |
| rob_frame | input | 1 | High at the boundary in signalling frames |
| sig_in | input | 1 | Signalling input stream bit for the starting channel |
| bp_tx_in | input | 8 | Transmit backplane byte |
| line_rx_in | input | 8 | Received line byte |
| line_tx_out | output | 8 | Byte sent to the line |
| bp_rx_out | output | 8 | Byte sent to the receive backplane |

## Verification
The bench writes a loop bit in the middle of a channel and checks that the outputs keep the old behaviour until that channel comes round again. A design that latched words continuously would switch partway through the byte. It drives robbing frames with bit 0 set and with E1 mode selected. A design that ignored the mode or the suppression bit would corrupt the LSB of the payload. It checks that the signalling bit follows sig_in only while bit 1 is clear. A design that reversed that sense would lose register-written signalling. It also writes to channels 24..31 in T1 mode. A design without the range check would keep and apply words for channels that do not exist.

// File: rtl/ts_ctrl.sv
module ts_ctrl #(
  parameter int N_E1 = 32,
  parameter int N_T1 = 24,
  parameter int DW   = 8,
  localparam int AW  = $clog2(N_E1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_e1,
  input  logic          reg_we,
  input  logic [AW:0]   reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ts_start,
  input  logic [AW-1:0] ts_num,
  input  logic          rob_frame,
  input  logic          sig_in,
  input  logic [DW-1:0] bp_tx_in,
  input  logic [DW-1:0] line_rx_in,
  output logic [DW-1:0] line_tx_out,
  output logic [DW-1:0] bp_rx_out
);
  localparam int B_CC = 0, B_SRC = 1, B_LTX = 4, B_LRX = 5;

  logic [DW-1:0] ctrl_q [N_E1];
  logic [N_E1-1:0] sig_q;
  logic [DW-1:0] act_q;
  logic act_sig, act_rob, act_vld;

  logic [AW:0] n_ch;
  logic wr_ok, ts_ok;
  logic [AW-1:0] ra;
  assign ra    = reg_addr[AW-1:0];
  assign n_ch  = mode_e1 ? (AW+1)'(N_E1) : (AW+1)'(N_T1);
  assign wr_ok = {1'b0, ra} < n_ch;
  assign ts_ok = {1'b0, ts_num} < n_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_E1; i++) ctrl_q[i] <= '0;
      sig_q <= '0;
    end else begin
      if (reg_we && wr_ok) begin
        if (reg_addr[AW]) sig_q[ra] <= reg_wdata[0];
        else              ctrl_q[ra] <= reg_wdata;
      end
      if (ts_start && ts_ok && !ctrl_q[ts_num][B_SRC])
        sig_q[ts_num] <= sig_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      act_sig <= 1'b0;
      act_rob <= 1'b0;
      act_vld <= 1'b0;
    end else if (ts_start) begin
      act_q   <= ts_ok ? ctrl_q[ts_num] : '0;
      act_sig <= ctrl_q[ts_num][B_SRC] ? sig_q[ts_num] : sig_in;
      act_rob <= rob_frame;
      act_vld <= ts_ok;
    end
  end

  logic rob_en;
  logic [DW-1:0] tx_pay;
  assign rob_en = !mode_e1 && act_vld && act_rob && !act_q[B_CC];
  assign tx_pay = rob_en ? {bp_tx_in[DW-1:1], act_sig} : bp_tx_in;

  assign line_tx_out = act_q[B_LRX] ? line_rx_in : tx_pay;
  assign bp_rx_out   = act_q[B_LTX] ? bp_tx_in   : line_rx_in;

  assign reg_rdata = !wr_ok        ? '0 :
                     reg_addr[AW]  ? {{(DW-1){1'b0}}, sig_q[ra]} : ctrl_q[ra];
endmodule

module ts_ctrl_chk #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int N_T1 = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_e1,
  input logic          reg_we,
  input logic [AW:0]   reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          ts_start,
  input logic [DW-1:0] bp_tx_in,
  input logic [DW-1:0] line_rx_in,
  input logic [DW-1:0] line_tx_out,
  input logic [DW-1:0] bp_rx_out,
  input logic [DW-1:0] act_q
);
  p_rdback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr[AW] && (mode_e1 || reg_addr[AW-1:0] < AW'(N_T1)))
    |=> (reg_addr != $past(reg_addr)) || !$stable(mode_e1) || (reg_rdata == $past(reg_wdata)));

  p_t1_hole_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_e1 && reg_addr[AW-1:0] >= AW'(N_T1)) |-> reg_rdata == '0);

  p_ltx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q[4] |-> bp_rx_out == bp_tx_in);

  p_lrx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q[5] |-> line_tx_out == line_rx_in);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_start |=> $stable(act_q));

  p_e1_norob_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e1 && !act_q[5]) |-> line_tx_out == bp_tx_in);
endmodule

bind ts_ctrl ts_ctrl_chk #(.AW(AW), .DW(DW), .N_T1(N_T1)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ts_start(ts_start), .bp_tx_in(bp_tx_in), .line_rx_in(line_rx_in),
  .line_tx_out(line_tx_out), .bp_rx_out(bp_rx_out), .act_q(act_q)
);

// File: tb/test_ts_ctrl.sv
module test_ts_ctrl;
  logic clk = 0, rst_n = 0, mode_e1 = 0, reg_we = 0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ts_start = 0, rob_frame = 0, sig_in = 0;
  logic [4:0] ts_num = '0;
  logic [7:0] bp_tx_in = '0, line_rx_in = '0, line_tx_out, bp_rx_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ts_ctrl i_ts_ctrl (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic bank, int n, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = {bank, 5'(n)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(string req, logic bank, int n, logic [7:0] exp);
    @(negedge clk);
    reg_addr = {bank, 5'(n)};
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic slot(int n, logic [7:0] tx, logic [7:0] rx, logic s, logic rob);
    @(negedge clk);
    ts_num = 5'(n); ts_start = 1; sig_in = s; rob_frame = rob;
    bp_tx_in = tx; line_rx_in = rx;
    @(negedge clk);
    ts_start = 0; sig_in = 0; rob_frame = 0;
  endtask

  task automatic outs(string req, logic [7:0] etx, logic [7:0] erx);
    #1;
    chk({req, " line_tx_out"}, line_tx_out, etx);
    chk({req, " bp_rx_out"}, bp_rx_out, erx);
  endtask

  task automatic t_reset;
    rd("R10 word", 0, 7, 8'h00);
    rd("R10 sig", 1, 7, 8'h00);
    slot(7, 8'h3C, 8'hC3, 0, 1);
    outs("R10", 8'h3C, 8'hC3);
  endtask

  task automatic t_rw;
    mode_e1 = 0;
    wr(0, 2, 8'hCC);
    rd("R1 readback", 0, 2, 8'hCC);
    slot(2, 8'h5A, 8'hA5, 0, 0);
    outs("R1 inert bits", 8'h5A, 8'hA5);
    wr(0, 2, 8'h00);
  endtask

  task automatic t_t1_range;
    mode_e1 = 0;
    wr(0, 26, 8'h30);
    rd("R2 T1 ctrl hole", 0, 26, 8'h00);
    wr(1, 26, 8'h01);
    rd("R2 T1 sig hole", 1, 26, 8'h00);
    slot(26, 8'h40, 8'h81, 1, 1);
    outs("R2 pass", 8'h40, 8'h81);
    mode_e1 = 1;
    rd("R2 write dropped", 0, 26, 8'h00);
    wr(0, 26, 8'h30);
    rd("R2 E1 store", 0, 26, 8'h30);
    mode_e1 = 0;
    rd("R2 T1 hides", 0, 26, 8'h00);
    mode_e1 = 1; wr(0, 26, 8'h00); mode_e1 = 0;
  endtask

  task automatic t_ltx;
    wr(0, 9, 8'h10);
    slot(9, 8'h11, 8'h22, 0, 0);
    outs("R3", 8'h11, 8'h11);
    wr(0, 9, 8'h00);
  endtask

  task automatic t_lrx;
    wr(0, 10, 8'h20);
    slot(10, 8'h11, 8'h22, 0, 1);
    outs("R4", 8'h22, 8'h22);
    wr(0, 10, 8'h00);
  endtask

  task automatic t_both;
    wr(0, 11, 8'h30);
    slot(11, 8'h6E, 8'h91, 0, 0);
    outs("R5", 8'h91, 8'h6E);
    wr(0, 11, 8'h00);
  endtask

  task automatic t_timing;
    slot(3, 8'h0F, 8'hF0, 0, 0);
    outs("R6 before", 8'h0F, 8'hF0);
    wr(0, 3, 8'h30);
    #1 chk("R6 mid-slot tx", line_tx_out, 8'h0F);
    chk("R6 mid-slot rx", bp_rx_out, 8'hF0);
    slot(3, 8'h0F, 8'hF0, 0, 0);
    outs("R6 after", 8'hF0, 8'h0F);
    wr(0, 3, 8'h00);
  endtask

  task automatic t_sig;
    mode_e1 = 0;
    slot(5, 8'h00, 8'h00, 1, 0);
    rd("R7 refresh 1", 1, 5, 8'h01);
    slot(5, 8'h00, 8'h00, 0, 0);
    rd("R7 refresh 0", 1, 5, 8'h00);
    wr(0, 5, 8'h02);
    wr(1, 5, 8'h01);
    slot(5, 8'h00, 8'h00, 0, 0);
    rd("R7 held", 1, 5, 8'h01);
  endtask

  task automatic t_rob;
    mode_e1 = 0;
    slot(5, 8'hA4, 8'h00, 0, 1);
    outs("R8 reg bit", 8'hA5, 8'h00);
    slot(5, 8'hA4, 8'h00, 0, 0);
    outs("R8 no frame", 8'hA4, 8'h00);
    wr(0, 5, 8'h00);
    slot(6, 8'h20, 8'h00, 1, 1);
    outs("R8 stream bit", 8'h21, 8'h00);
    slot(6, 8'h21, 8'h00, 0, 1);
    outs("R8 stream zero", 8'h20, 8'h00);
  endtask

  task automatic t_cc;
    mode_e1 = 0;
    wr(0, 12, 8'h01);
    slot(12, 8'h20, 8'h00, 1, 1);
    outs("R9 T1 clear channel", 8'h20, 8'h00);
    wr(0, 12, 8'h00);
    mode_e1 = 1;
    slot(28, 8'h20, 8'h00, 1, 1);
    outs("R9 E1 no rob", 8'h20, 8'h00);
    wr(0, 13, 8'h01);
    slot(13, 8'h7E, 8'h00, 0, 0);
    outs("R9 E1 bit0 inert", 8'h7E, 8'h00);
    wr(0, 13, 8'h00);
    mode_e1 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_t1_range();
    t_ltx();
    t_lrx();
    t_both();
    t_timing();
    t_sig();
    t_rob();
    t_cc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule